// File: doc/BRIEF.md
# Dual-Slope Integrating ADC Timing Controller

This block drives the digital half of a dual-slope integrating analog-to-digital converter. The integrator, its comparator and the analog switch sit outside. The block controls the switch through a single source-select line. After a start request it holds the integrator on the unknown input for a programmable number of ticks. It then switches the integrator to the known reference. From that point it counts ticks for as long as the comparator output stays active. When the comparator drops, it captures the count as the conversion result.

One tick is a fixed number of clocks, two by default. A 16-bit full-scale count from a 10 MHz clock therefore spans about 13.1 ms. A smaller full-scale limit can be programmed to shorten conversions at reduced resolution. If the comparator is still active when the count reaches that limit, the result saturates and an over-range flag is raised.

Every finished conversion produces a one-cycle done pulse. After it, a programmable settle gap lets the integrator discharge before another start is accepted.

Top module: `dslope_adc_ctrl`

## Requirements
- R1: After reset and while idle or integrating the input, `sel_ref_o` is 0 (unknown input selected). It is 1 only during the de-integration phase, and it returns to 0 on the same clock edge that raises `done_o`.
- R2: An accepted start enters the integrate phase. That phase lasts `int_period_i` ticks of PRESCALE clocks each, that is 2*`int_period_i` clocks by default. A value of 0 is treated as 1. `sel_ref_o` rises on the edge that ends the last tick.
- R3: During de-integration the count advances once per tick, and only while the synchronized comparator input is 1. The tick phase restarts at the edge where `sel_ref_o` rises.
- R4: `comp_i` passes through a two-flop synchronizer. A conversion ends when the synchronized comparator reads 0. If `comp_i` falls between the m-th and (m+1)-th edges after `sel_ref_o` rises, the result is floor((m+2)/2) with the default PRESCALE of 2.
- R5: If the count equals `max_count_i` while the synchronized comparator is still 1, the conversion ends with `result_o` equal to `max_count_i` and `overrange_o` equal to 1. A normal end sets `overrange_o` to 0.
- R6: `done_o` is high for exactly one cycle per conversion. `result_o` and `overrange_o` change only together with `done_o` and hold their values until the next pulse.
- R7: `start_i` is ignored while a conversion is in its integrate or de-integrate phase.
- R8: After `done_o` the block waits `gap_i` clocks (at least 1) with `sel_ref_o` at 0. A start during this gap is ignored.
- R9: Reset (active-low `rst_ni`, asynchronous) clears `result_o`, `overrange_o`, `done_o` and `sel_ref_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled when idle |
| int_period_i | input | CNT_W | Integrate phase length in ticks |
| max_count_i | input | CNT_W | Full-scale count limit |
| gap_i | input | GAP_W | Settle gap in clocks after each conversion |
| comp_i | input | 1 | Asynchronous comparator output, 1 = integrator above threshold |
| sel_ref_o | output | 1 | Integrator source: 0 = unknown input, 1 = reference |
| done_o | output | 1 | One-cycle pulse when a result is captured |
| result_o | output | CNT_W | Captured count |
| overrange_o | output | 1 | Set when the result saturated at the limit |

## Verification
Some properties are checked on every clock. These are the single-cycle done pulse, the result and over-range flag holding between pulses, saturation to the programmed limit whenever over-range is reported, and the reference select dropping together with done and staying low in the cycle after it. The bench scenarios cover what depends on timing and stimulus. That includes the integrate-phase length for several periods and the exact count for comparator falls at different tick phases. It also includes the synchronizer latency folded into that count, start pulses arriving mid-conversion or inside the settle gap, and a comparator that never drops.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_INTEG  = 2'd1,
      ST_DEINT  = 2'd2,
      ST_SETTLE = 2'd3
   } dsadc_state_e;
endpackage

// File: rtl/dsadc_sync.sv
// Multi-stage synchronizer for an asynchronous level input.
module dsadc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("dsadc_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= d_i;
      end
   end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_tick.sv
// Tick generator: one pulse every DIV clocks, phase restarted by clr_i.
module dsadc_tick #(
   parameter int DIV = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic tick_o
);
   if (DIV < 1) begin : g_bad_div
      $error("dsadc_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, clr_i};
      assign tick_o    = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] phase_q;
      assign tick_o = (phase_q == PW'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     phase_q <= '0;
         else if (clr_i)  phase_q <= '0;
         else if (tick_o) phase_q <= '0;
         else             phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/dsadc_counter.sv
// Plain up-counter with synchronous clear and enable.
module dsadc_counter #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         en_i,
   output logic [W-1:0] cnt_o
);
   if (W < 1) begin : g_bad_w
      $error("dsadc_counter: W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else if (en_i)  cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/dslope_adc_ctrl.sv
module dslope_adc_ctrl
   import dsadc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int GAP_W       = 8,
   parameter int PRESCALE    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [CNT_W-1:0] int_period_i,
   input  logic [CNT_W-1:0] max_count_i,
   input  logic [GAP_W-1:0] gap_i,
   input  logic             comp_i,
   output logic             sel_ref_o,
   output logic             done_o,
   output logic [CNT_W-1:0] result_o,
   output logic             overrange_o
);
   localparam int CW1 = CNT_W + 1;
   localparam int GW1 = GAP_W + 1;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("dslope_adc_ctrl: CNT_W must be at least 2");
   end
   if (GAP_W < 1) begin : g_bad_gap
      $error("dslope_adc_ctrl: GAP_W must be at least 1");
   end

   dsadc_state_e state_q, state_d;
   logic         comp_s;
   logic         tick;
   logic [CNT_W-1:0] phase_cnt, meas_cnt;
   logic [GAP_W-1:0] gap_cnt;
   logic         integ_last, settle_last, at_max, meas_end, sat_end;

   dsadc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(comp_i), .q_o(comp_s)
   );

   dsadc_tick #(.DIV(PRESCALE)) i_tick (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .clr_i (state_d != state_q), .tick_o(tick)
   );

   dsadc_counter #(.W(CNT_W)) i_phase_cnt (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .clr_i (state_q != ST_INTEG),
      .en_i  (tick),
      .cnt_o (phase_cnt)
   );

   dsadc_counter #(.W(CNT_W)) i_meas_cnt (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .clr_i (state_q != ST_DEINT),
      .en_i  (tick && comp_s && !at_max),
      .cnt_o (meas_cnt)
   );

   dsadc_counter #(.W(GAP_W)) i_gap_cnt (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .clr_i (state_q != ST_SETTLE),
      .en_i  (1'b1),
      .cnt_o (gap_cnt)
   );

   assign integ_last  = tick && ((CW1'(phase_cnt) + 1'b1) >= CW1'(int_period_i));
   assign settle_last = (GW1'(gap_cnt) + 1'b1) >= GW1'(gap_i);
   assign at_max      = (meas_cnt == max_count_i);
   assign meas_end    = !comp_s;
   assign sat_end     = comp_s && at_max;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start_i)              state_d = ST_INTEG;
         ST_INTEG:  if (integ_last)           state_d = ST_DEINT;
         ST_DEINT:  if (meas_end || sat_end)  state_d = ST_SETTLE;
         ST_SETTLE: if (settle_last)          state_d = ST_IDLE;
         default:                             state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         done_o      <= 1'b0;
         result_o    <= '0;
         overrange_o <= 1'b0;
      end else begin
         state_q <= state_d;
         done_o  <= 1'b0;
         if (state_q == ST_DEINT) begin
            if (meas_end) begin
               result_o    <= meas_cnt;
               overrange_o <= 1'b0;
               done_o      <= 1'b1;
            end else if (sat_end) begin
               result_o    <= max_count_i;
               overrange_o <= 1'b1;
               done_o      <= 1'b1;
            end
         end
      end
   end

   assign sel_ref_o = (state_q == ST_DEINT);
endmodule

// File: rtl/dslope_adc_ctrl_chk.sv
module dslope_adc_ctrl_chk #(
   parameter int CNT_W       = 16,
   parameter int GAP_W       = 8,
   parameter int PRESCALE    = 2,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic [CNT_W-1:0] int_period_i,
   input logic [CNT_W-1:0] max_count_i,
   input logic [GAP_W-1:0] gap_i,
   input logic             comp_i,
   input logic             sel_ref_o,
   input logic             done_o,
   input logic [CNT_W-1:0] result_o,
   input logic             overrange_o
);
   logic unused_chk;
   assign unused_chk = ^{start_i, int_period_i, gap_i, comp_i};

   assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> ($stable(result_o) && $stable(overrange_o)));

   assert_sat_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && overrange_o) |-> (result_o == max_count_i));

   assert_within_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !overrange_o) |-> (result_o <= max_count_i));

   assert_ref_off_at_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> $fell(sel_ref_o));

   assert_gap_input_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(done_o) |-> !sel_ref_o);
endmodule

bind dslope_adc_ctrl dslope_adc_ctrl_chk #(
   .CNT_W(CNT_W), .GAP_W(GAP_W), .PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES)
) i_dslope_adc_ctrl_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
   .int_period_i(int_period_i), .max_count_i(max_count_i), .gap_i(gap_i),
   .comp_i(comp_i), .sel_ref_o(sel_ref_o), .done_o(done_o),
   .result_o(result_o), .overrange_o(overrange_o)
);

// File: tb/test_dslope_adc_ctrl.sv
module test_dslope_adc_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 16;
   localparam int GAP_W = 8;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic             start_i = 1'b0;
   logic [CNT_W-1:0] int_period_i = 16'd1;
   logic [CNT_W-1:0] max_count_i = 16'hFFFF;
   logic [GAP_W-1:0] gap_i = 8'd3;
   logic             comp_i = 1'b1;
   logic             sel_ref_o, done_o, overrange_o;
   logic [CNT_W-1:0] result_o;

   typedef struct packed {
      logic [CNT_W-1:0] res;
      logic             ovr;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    fails  = 0;
   int    dones  = 0;
   bit    finished = 1'b0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   dslope_adc_ctrl i_dslope_adc_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
      .int_period_i(int_period_i), .max_count_i(max_count_i), .gap_i(gap_i),
      .comp_i(comp_i), .sel_ref_o(sel_ref_o), .done_o(done_o),
      .result_o(result_o), .overrange_o(overrange_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // Monitor: pops expected results as done pulses appear (R4, R5, R6).
   logic done_prev = 1'b0;
   always @(negedge clk_i) begin
      if (rst_ni) begin
         if (done_o && done_prev) check(1'b0, "R6 done longer than one cycle", 2, 1);
         if (done_o) begin
            dones++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected conversion", dones, dones - 1);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(result_o == e.res, {t, " result"}, result_o, e.res);
               check(overrange_o == e.ovr, {t, " overrange"}, overrange_o, e.ovr);
            end
         end
      end
      done_prev = done_o;
   end

   // Driver: one conversion. The comparator falls m edges after the select rises
   // (sat: never falls). mid_start pulses start during de-integration (R7).
   task automatic convert(input int per, input int m, input int maxc, input bit sat,
                          input bit mid_start, input string tag);
      exp_t e;
      int   n;
      int   gap_wait;
      int_period_i = CNT_W'(per);
      max_count_i  = CNT_W'(maxc);
      e.res = sat ? CNT_W'(maxc) : CNT_W'((m + 2) / 2);
      e.ovr = sat;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      comp_i = 1'b1;
      @(negedge clk_i); start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      n = 1;
      while (!sel_ref_o) begin
         @(negedge clk_i);
         n++;
      end
      // R2: select rises 2*per clocks after the accepting edge
      check(n == 2 * ((per == 0) ? 1 : per) + 1, "R2 integrate length", n,
            2 * ((per == 0) ? 1 : per) + 1);
      if (!sat) begin
         if (mid_start) begin
            @(negedge clk_i); start_i = 1'b1;
            @(negedge clk_i); start_i = 1'b0;
            repeat (m - 2) @(negedge clk_i);
         end else begin
            repeat (m) @(negedge clk_i);
         end
         comp_i = 1'b0;
      end
      while (!done_o) @(negedge clk_i);
      // R1: select low once done is seen
      check(sel_ref_o == 1'b0, "R1 select after done", sel_ref_o, 0);
      comp_i = 1'b1;
      gap_wait = int'(gap_i) + 3;
      repeat (gap_wait) @(negedge clk_i);
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      check(1'b0, "watchdog expired", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk_i);
      // R9: reset state
      check(sel_ref_o == 1'b0, "R9 sel_ref reset", sel_ref_o, 0);
      check(done_o == 1'b0, "R9 done reset", done_o, 0);
      check(result_o == '0, "R9 result reset", result_o, 0);
      check(overrange_o == 1'b0, "R9 overrange reset", overrange_o, 0);
      rst_ni = 1'b1;
      repeat (2) @(negedge clk_i);
      check(sel_ref_o == 1'b0, "R1 idle select", sel_ref_o, 0);

      convert(1, 0, 1000, 1'b0, 1'b0, "R4 m0");
      convert(3, 5, 1000, 1'b0, 1'b0, "R3 m5");
      convert(8, 10, 1000, 1'b0, 1'b0, "R3 m10");
      convert(0, 13, 1000, 1'b0, 1'b0, "R4 m13 period0");
      convert(2, 40, 5, 1'b1, 1'b0, "R5 saturate");
      convert(2, 6, 100, 1'b0, 1'b0, "R6 overrange clears");
      convert(4, 9, 1000, 1'b0, 1'b1, "R7 start mid conversion");

      // R8: start inside settle gap is ignored
      gap_i = 8'd20;
      int_period_i = 16'd1;
      exp_q.push_back('{res: CNT_W'(3), ovr: 1'b0});
      tag_q.push_back("R8 before gap");
      @(negedge clk_i); start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      while (!sel_ref_o) @(negedge clk_i);
      repeat (4) @(negedge clk_i);
      comp_i = 1'b0;
      while (!done_o) @(negedge clk_i);
      comp_i = 1'b1;
      @(negedge clk_i); start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      begin
         int seen = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk_i);
            if (sel_ref_o) seen++;
         end
         check(seen == 0, "R8 start in gap ignored", seen, 0);
      end
      gap_i = 8'd3;
      convert(1, 3, 1000, 1'b0, 1'b0, "R8 after gap");

      repeat (10) @(negedge clk_i);
      check(dones == 9, "R6 one done per conversion", dones, 9);
      check(exp_q.size() == 0, "R7 no missing results", exp_q.size(), 0);
      report();
   end
endmodule